// File: doc/BRIEF.md
# Linear11 Overcurrent-Warning Limit Register

This block holds the output-current warning threshold of a multiphase regulator controller. A host writes the threshold as a 16-bit word in the Linear11 floating format over a word-write port selected by command code `0x4A`. It reads the same word back through a word-read port. Every write is checked before it is accepted. A write with a negative mantissa, or with a value above the legal ceiling, is dropped and produces a one-cycle invalid-data pulse. The legal ceiling is 31 A times the active phase count.

From the accepted value the block derives a 5-bit hardware threshold code for each phase. The code is on a 1 A grid, rounded up, and held between 4 A and 31 A. The block also models a nonvolatile backup. A store pulse quantizes the live value to the nearest quarter ampere and keeps it. A restore pulse, or a reset, reloads the register from that copy with an exponent of −2.

Top module: `l11_limit_reg`

## Requirements
- R1: A word write whose command code is 0x4A and whose data is valid is stored unchanged. A word read with command code 0x4A returns the stored word. A write with any other command code leaves the register alone. A read with any other command code returns 0x0000.
- R2: The word is interpreted as follows. Bits 15:11 are a two's-complement exponent e. Bits 10:0 are a two's-complement mantissa m. The value in amperes is m × 2^e.
- R3: A write to 0x4A is rejected when m is negative or when the value exceeds 31 A × active phases. A rejected write leaves the stored word unchanged and drives `inv_data` high for exactly the cycle after the write.
- R4: `phase_cnt` values 1..NPH set the active phase count. The values 0 and anything above NPH count as one phase.
- R5: Lane i of `hw_code` is bits [5i+4:5i]. For each active lane it equals ceil(value / phases) clamped to 4..31 A, minus 4, so 0 means 4 A and 27 means 31 A. Inactive lanes read 0. The lanes follow a register change one clock later.
- R6: A store pulse saves the live value rounded to the nearest 0.25 A, with halves rounded up and the result capped at 31 A.
- R7: A restore pulse loads the word {11110b, saved quarter count}, that is, exponent −2.
- R8: While reset is held, the stored word is {11110b, NVM_INIT_QA}, the saved copy equals NVM_INIT_QA, `inv_data` is 0 and every `hw_code` lane is 0.
- R9: An accepted write in the same cycle as a restore wins over the restore. A store in the same cycle as a write saves the value held before that write. A rejected write in the same cycle as a restore lets the restore take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (models power-up) |
| wr_en | input | 1 | Word-write strobe |
| wr_cmd | input | 8 | Command code of the write |
| wr_data | input | 16 | Linear11 write word |
| rd_cmd | input | 8 | Command code of the read |
| rd_data | output | 16 | Read word (0 when the code does not match) |
| phase_cnt | input | 3 | Active phase count |
| store_pulse | input | 1 | Save the quantized value to the backup copy |
| restore_pulse | input | 1 | Reload the register from the backup copy |
| inv_data | output | 1 | One-cycle pulse after a rejected write |
| hw_code | output | 20 | Per-phase threshold codes, 5 bits per lane |

## Verification
Three of the block's actions can land in the same cycle: a word write, a store and a restore. The bench pairs a write with a store or a restore on the same clock edge, in both the accepted and the rejected form. It judges the outcome from the read port and `inv_data` one clock later. A restore that follows confirms which value the backup copy captured.

// File: rtl/l11_pkg.sv
// Shared types and constants for the Linear11 limit register.
// Assumes a 16-bit word: 5-bit exponent on top, 11-bit mantissa below.
package l11_pkg;
    localparam int L11_EXP_W = 5;
    localparam int L11_MAN_W = 11;
    localparam int QA_W      = 28;     // quarter-ampere working width
    localparam int QPA       = 4;      // quarter steps per ampere
    localparam logic [L11_EXP_W-1:0] EXP_QUARTER = 5'b11110;

    typedef struct packed {
        logic [L11_EXP_W-1:0] exp;
        logic [L11_MAN_W-1:0] man;
    } l11_word_t;
endpackage

// File: rtl/l11_decode.sv
// Converts a Linear11 word into quarter-ampere quantities.
// Outputs: the validity against the phase-scaled ceiling, the count rounded
// up to a quarter step, and a nearest-quarter count capped for backup.
// Assumes nph_i is already forced into 1..NPH by the caller.
module l11_decode
    import l11_pkg::*;
#(
    parameter int PHW        = 3,
    parameter int MAX_QA     = 124,
    parameter int NVW        = 7
) (
    input  logic [15:0]     word_i,
    input  logic [PHW-1:0]  nph_i,
    output logic            ok_o,
    output logic [QA_W-1:0] qceil_o,
    output logic [NVW-1:0]  qnear_o
);
    l11_word_t          w;
    logic signed [5:0]  sh;
    logic [4:0]         k;
    logic [QA_W-1:0]    mag, q, lim, lowmask, qn;
    logic               rem, half, neg, over;

    // Shift the mantissa into quarter units and flag any discarded bits
    always_comb begin
        w       = word_i;
        neg     = w.man[L11_MAN_W-1];
        mag     = QA_W'(w.man[L11_MAN_W-2:0]);
        sh      = $signed({w.exp[L11_EXP_W-1], w.exp}) + 6'sd2;
        lim     = QA_W'(MAX_QA) * QA_W'(nph_i);
        k       = 5'd0;
        lowmask = '0;
        if (sh >= 6'sd0) begin
            q    = mag << sh[4:0];
            rem  = 1'b0;
            half = 1'b0;
        end else begin
            k       = 5'(-sh);
            lowmask = (QA_W'(1) << k) - QA_W'(1);
            q       = mag >> k;
            rem     = |(mag & lowmask);
            half    = mag[k - 5'd1];
        end
        over    = (q > lim) || ((q == lim) && rem);
        ok_o    = !neg && !over;
        qceil_o = q + QA_W'(rem);
        qn      = q + QA_W'(half);
        qnear_o = (qn > QA_W'(MAX_QA)) ? NVW'(MAX_QA) : qn[NVW-1:0];
    end
endmodule

// File: rtl/l11_hwcode.sv
// Picks the smallest whole-ampere per-phase threshold that covers the
// requested total, within HW_MIN_A..HW_MAX_A, and returns it minus HW_MIN_A.
// Assumes qceil_i is already rounded up to a quarter step.
module l11_hwcode
    import l11_pkg::*;
#(
    parameter int PHW      = 3,
    parameter int HW_MIN_A = 4,
    parameter int HW_MAX_A = 31,
    parameter int CW       = 5
) (
    input  logic [QA_W-1:0] qceil_i,
    input  logic [PHW-1:0]  nph_i,
    output logic [CW-1:0]   code_o
);
    // Scan downward so the last match is the smallest covering step
    always_comb begin
        code_o = CW'(HW_MAX_A - HW_MIN_A);
        for (int t = HW_MAX_A; t >= HW_MIN_A; t--) begin
            if (QA_W'(QPA * t) * QA_W'(nph_i) >= qceil_i)
                code_o = CW'(t - HW_MIN_A);
        end
    end
endmodule

// File: rtl/l11_limit_reg.sv
// Overcurrent-warning limit register. It accepts Linear11 word writes on
// one command code, rejects bad data, derives per-phase hardware codes and
// models a quarter-ampere backup copy. Assumes single-cycle strobes on the
// write, store and restore inputs, with a synchronous active-low reset.
module l11_limit_reg
    import l11_pkg::*;
#(
    parameter int          NPH             = 4,
    parameter logic [7:0]  CMD_CODE        = 8'h4A,
    parameter int          MAX_A_PER_PHASE = 31,
    parameter int          HW_MIN_A        = 4,
    parameter int          NVM_INIT_QA     = 80,
    localparam int         PHW    = $clog2(NPH + 1),
    localparam int         MAX_QA = MAX_A_PER_PHASE * QPA,
    localparam int         NVW    = $clog2(MAX_QA + 1),
    localparam int         CW     = $clog2(MAX_A_PER_PHASE - HW_MIN_A + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_cmd,
    input  logic [15:0]        wr_data,
    input  logic [7:0]         rd_cmd,
    output logic [15:0]        rd_data,
    input  logic [PHW-1:0]     phase_cnt,
    input  logic               store_pulse,
    input  logic               restore_pulse,
    output logic               inv_data,
    output logic [NPH*CW-1:0]  hw_code
);
    logic [15:0]     limit_q;
    logic [NVW-1:0]  nvm_q;
    logic [PHW-1:0]  nph_eff;
    logic            wr_hit, wr_ok, cur_ok;
    logic [QA_W-1:0] wr_qceil, cur_qceil;
    logic [NVW-1:0]  wr_qnear, cur_qnear;
    logic [CW-1:0]   code_cur;

    // Out-of-range phase counts fall back to a single phase
    always_comb begin
        nph_eff = ((phase_cnt == '0) || (phase_cnt > PHW'(NPH))) ? PHW'(1) : phase_cnt;
        wr_hit  = wr_en && (wr_cmd == CMD_CODE);
    end

    l11_decode #(.PHW(PHW), .MAX_QA(MAX_QA), .NVW(NVW)) u_dec_wr (
        .word_i (wr_data), .nph_i (nph_eff),
        .ok_o (wr_ok), .qceil_o (wr_qceil), .qnear_o (wr_qnear)
    );

    l11_decode #(.PHW(PHW), .MAX_QA(MAX_QA), .NVW(NVW)) u_dec_cur (
        .word_i (limit_q), .nph_i (nph_eff),
        .ok_o (cur_ok), .qceil_o (cur_qceil), .qnear_o (cur_qnear)
    );

    l11_hwcode #(.PHW(PHW), .HW_MIN_A(HW_MIN_A), .HW_MAX_A(MAX_A_PER_PHASE), .CW(CW)) u_code (
        .qceil_i (cur_qceil), .nph_i (nph_eff), .code_o (code_cur)
    );

    // Live register: an accepted write beats a restore
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_q <= {EXP_QUARTER, L11_MAN_W'(NVM_INIT_QA)};
        else if (wr_hit && wr_ok)
            limit_q <= wr_data;
        else if (restore_pulse)
            limit_q <= {EXP_QUARTER, L11_MAN_W'(nvm_q)};
    end

    // Backup copy: captures the nearest quarter of the pre-write value
    always_ff @(posedge clk) begin
        if (!rst_n)
            nvm_q <= NVW'(NVM_INIT_QA);
        else if (store_pulse)
            nvm_q <= cur_qnear;
    end

    // Invalid-data pulse for one cycle after a rejected write
    always_ff @(posedge clk) begin
        if (!rst_n) inv_data <= 1'b0;
        else        inv_data <= wr_hit && !wr_ok;
    end

    // Per-phase code lanes; lanes beyond the active count are held at 0
    for (genvar g = 0; g < NPH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                hw_code[g*CW +: CW] <= '0;
            else
                hw_code[g*CW +: CW] <= (PHW'(g) < nph_eff) ? code_cur : '0;
        end
    end

    // Read mux: only the owned command code returns data
    always_comb rd_data = (rd_cmd == CMD_CODE) ? limit_q : 16'h0000;

    // Decoder side outputs that the register path does not consume
    logic unused_ok;
    always_comb unused_ok = ^{cur_ok, wr_qceil, wr_qnear};
endmodule

// File: rtl/l11_limit_reg_chk.sv
// Property checker for l11_limit_reg, attached with bind below.
module l11_limit_reg_chk #(
    parameter int         NPH      = 4,
    parameter int         CW       = 5,
    parameter int         NVW      = 7,
    parameter int         PHW      = 3,
    parameter int         MAX_QA   = 124,
    parameter logic [7:0] CMD_CODE = 8'h4A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_cmd,
    input logic [15:0]       wr_data,
    input logic [PHW-1:0]    phase_cnt,
    input logic              store_pulse,
    input logic              restore_pulse,
    input logic              inv_data,
    input logic [NPH*CW-1:0] hw_code,
    input logic [15:0]       limit_q,
    input logic [NVW-1:0]    nvm_q
);
    AST_ACCEPT_OR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd == CMD_CODE) |=> (limit_q == $past(wr_data)) || inv_data); // R1
    AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        inv_data |-> $past(wr_en && wr_cmd == CMD_CODE)); // R3
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_data && !$past(restore_pulse)) |-> $stable(limit_q)); // R3
    AST_SINGLE_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_cnt) == PHW'(1)) |-> (hw_code[(NPH-1)*CW +: CW] == '0)); // R4
    AST_CODE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        hw_code[CW-1:0] <= CW'(MAX_QA/4 - 4)); // R5
    AST_NVM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_q <= NVW'(MAX_QA)); // R6
    AST_NVM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !store_pulse |=> $stable(nvm_q)); // R6
    AST_RESTORE_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_pulse && !wr_en) |=> (limit_q[15:11] == 5'b11110)); // R7
endmodule

bind l11_limit_reg l11_limit_reg_chk #(
    .NPH(NPH), .CW(CW), .NVW(NVW), .PHW(PHW), .MAX_QA(MAX_QA), .CMD_CODE(CMD_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .phase_cnt(phase_cnt), .store_pulse(store_pulse), .restore_pulse(restore_pulse),
    .inv_data(inv_data), .hw_code(hw_code), .limit_q(limit_q), .nvm_q(nvm_q)
);

// File: tb/l11_limit_reg_bench.sv
`timescale 1ns/1ps
module l11_limit_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_cmd = 8'h4A;
    logic [15:0] wr_data = 16'h0;
    logic [7:0]  rd_cmd = 8'h4A;
    logic [15:0] rd_data;
    logic [2:0]  phase_cnt = 3'd1;
    logic        store_pulse = 1'b0;
    logic        restore_pulse = 1'b0;
    logic        inv_data;
    logic [19:0] hw_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    l11_limit_reg u_l11_limit_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .rd_cmd(rd_cmd), .rd_data(rd_data), .phase_cnt(phase_cnt),
        .store_pulse(store_pulse), .restore_pulse(restore_pulse),
        .inv_data(inv_data), .hw_code(hw_code)
    );

    // {word[24:9], phases[8:6], accepted[5], lane code[4:0]}
    localparam logic [24:0] VEC [16] = '{
        {16'hF050, 3'd1, 1'b1, 5'd16},
        {16'hF051, 3'd1, 1'b1, 5'd17},
        {16'hF07C, 3'd1, 1'b1, 5'd27},
        {16'hF07D, 3'd1, 1'b0, 5'd27},
        {16'h0002, 3'd1, 1'b1, 5'd0},
        {16'hF7FC, 3'd1, 1'b0, 5'd0},
        {16'h003E, 3'd2, 1'b1, 5'd27},
        {16'h003F, 3'd2, 1'b0, 5'd27},
        {16'hF819, 3'd2, 1'b1, 5'd3},
        {16'h083E, 3'd4, 1'b1, 5'd27},
        {16'hE864, 3'd4, 1'b1, 5'd0},
        {16'h7801, 3'd1, 1'b0, 5'd9},
        {16'h83FF, 3'd1, 1'b1, 5'd0},
        {16'hE8F1, 3'd1, 1'b1, 5'd27},
        {16'hE8F9, 3'd1, 1'b0, 5'd27},
        {16'h0032, 3'd3, 1'b1, 5'd13}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_lanes(input string req, input int n, input logic [4:0] code);
        for (int i = 0; i < 4; i++)
            chk(req, 32'(hw_code[i*5 +: 5]), (i < n) ? 32'(code) : 32'd0);
    endtask

    // Drives one write with optional store/restore in the same cycle
    task automatic wr_cycle(input logic [7:0] cmd, input logic [15:0] d,
                            input logic st, input logic rs);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = cmd; wr_data = d;
        store_pulse = st; restore_pulse = rs;
        @(negedge clk);
        wr_en = 1'b0; store_pulse = 1'b0; restore_pulse = 1'b0;
    endtask

    task automatic pulse(input logic st, input logic rs);
        @(negedge clk);
        store_pulse = st; restore_pulse = rs;
        @(negedge clk);
        store_pulse = 1'b0; restore_pulse = 1'b0;
    endtask

    initial begin
        logic [15:0] prev;
        repeat (3) @(negedge clk);
        chk("R8 word in reset", 32'(rd_data), 32'hF050);
        chk("R8 flag in reset", 32'(inv_data), 32'd0);
        chk("R8 codes in reset", 32'(hw_code), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_lanes("R5 code after reset", 1, 5'd16);
        prev = 16'hF050;

        // Vector table: R1 R2 R3 R5
        for (int i = 0; i < 16; i++) begin
            logic [24:0] v;
            v = VEC[i];
            @(negedge clk);
            phase_cnt = v[8:6];
            wr_en = 1'b1; wr_cmd = 8'h4A; wr_data = v[24:9];
            @(negedge clk);
            wr_en = 1'b0;
            chk("R3 flag", 32'(inv_data), v[5] ? 32'd0 : 32'd1);
            if (v[5]) prev = v[24:9];
            chk("R1 R2 readback", 32'(rd_data), 32'(prev));
            @(negedge clk);
            chk("R3 flag ends", 32'(inv_data), 32'd0);
            chk_lanes("R5 lanes", int'(v[8:6]), v[4:0]);
        end

        // R1: foreign command code ignored, foreign read returns 0
        wr_cycle(8'h4B, 16'hF060, 1'b0, 1'b0);
        chk("R1 foreign write flag", 32'(inv_data), 32'd0);
        chk("R1 foreign write", 32'(rd_data), 32'h0032);
        rd_cmd = 8'h4B;
        #1 chk("R1 foreign read", 32'(rd_data), 32'd0);
        rd_cmd = 8'h4A;

        // R4: phase count 0 and 7 count as one phase (50 A clamps to 31 A)
        @(negedge clk); phase_cnt = 3'd0;
        @(negedge clk); @(negedge clk);
        chk_lanes("R4 zero phases", 1, 5'd27);
        wr_cycle(8'h4A, 16'h0020, 1'b0, 1'b0);
        chk("R4 zero phases limit", 32'(inv_data), 32'd1);
        @(negedge clk); phase_cnt = 3'd7;
        @(negedge clk); @(negedge clk);
        chk_lanes("R4 over-range phases", 1, 5'd27);

        // R6 R7: 20.625 A rounds to 20.75 A in the backup copy
        @(negedge clk); phase_cnt = 3'd1;
        wr_cycle(8'h4A, 16'hE8A5, 1'b0, 1'b0);
        pulse(1'b1, 1'b0);
        wr_cycle(8'h4A, 16'hF010, 1'b0, 1'b0);
        pulse(1'b0, 1'b1);
        chk("R6 R7 restore rounded", 32'(rd_data), 32'hF053);
        @(negedge clk);
        chk_lanes("R5 after restore", 1, 5'd17);

        // R6: 62 A over two phases saves capped at 31 A
        @(negedge clk); phase_cnt = 3'd2;
        wr_cycle(8'h4A, 16'h003E, 1'b0, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        chk("R6 store cap", 32'(rd_data), 32'hF07C);
        @(negedge clk);
        chk_lanes("R5 two-phase split", 2, 5'd12);

        // R9: accepted write beats a restore in the same cycle
        @(negedge clk); phase_cnt = 3'd1;
        wr_cycle(8'h4A, 16'hF050, 1'b0, 1'b1);
        chk("R9 write over restore", 32'(rd_data), 32'hF050);

        // R9: store in the write cycle saves the older value
        wr_cycle(8'h4A, 16'hF060, 1'b1, 1'b0);
        chk("R9 write with store", 32'(rd_data), 32'hF060);
        pulse(1'b0, 1'b1);
        chk("R9 store saw old value", 32'(rd_data), 32'hF050);

        // R9 R3: rejected write lets a same-cycle restore through
        wr_cycle(8'h4A, 16'hF060, 1'b0, 1'b0);
        wr_cycle(8'h4A, 16'hF07D, 1'b0, 1'b1);
        chk("R9 rejected write with restore", 32'(rd_data), 32'hF050);
        chk("R3 flag with restore", 32'(inv_data), 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule